// File: doc/BRIEF.md
# UART Register Bank with Wishbone Slave Port

This block is the software-facing half of a full-duplex UART. A Wishbone master reaches four 32-bit word registers through it: a status word, a control word, a receive buffer and a transmit buffer. The serial transmitter and receiver sit beside it. The transmitter takes its character and a start strobe from this block and reports completion back. The receiver delivers finished characters together with their parity and framing verdicts. The bit timing on the serial lines is left entirely to those engines.

The bank keeps the line configuration and drives it to both engines: the divider, the character width, the parity mode and the stop-bit count. It holds the flags that report receive state and errors, and it applies the side effects of reads. Reading the receive buffer empties it. Reading the status word clears the sticky error flags. Any write to the control word sends a one-cycle abort to both engines. The bus side handles single classic read and write cycles only.

Top module: `uart_wb_regs`

## Requirements
- R1: After reset every register reads as zero, and `cancel_o` and `tx_start_o` are low.
- R2: A request is taken when `cyc_i` and `stb_i` are high while `ack_o` is low. `ack_o` is then high for exactly one cycle, the cycle after the accepting edge, and a read returns its data on `dat_o` in that same cycle.
- R3: The control word sits at byte offset 0x4. It holds the clock divider in bits [31:16], the character width in bit 0 (0 = seven, 1 = eight), the parity mode in bits [2:1] (00 none, 01 even, 10 odd) and the stop count in bit 3 (0 = one, 1 = two). It reads back those fields with all other bits zero. The fields appear on the configuration outputs in the ack cycle.
- R4: Every write to the control word raises `cancel_o` for exactly the ack cycle and clears the transmitter-busy flag.
- R5: A cycle with `rx_valid_i` high loads `rx_data_i` into the receive buffer (offset 0x8, bits [7:0]) and sets the receive-full flag, status bit 0.
- R6: A read of the receive buffer returns the character, then clears the buffer and status bit 0. A character arriving on the same edge wins.
- R7: A received character flagged with `rx_perr_i` sets status bit 4. One flagged with `rx_ferr_i` sets status bit 3. Both flags stay set until the status word is read.
- R8: A character that arrives while status bit 0 is set, and is not being read on the same edge, sets the overrun flag (status bit 2) and replaces the buffered character.
- R9: A read of the status word (offset 0x0) returns the flags as they were before the read, then clears bits 2, 3 and 4. Bits 0 and 1 are left alone. Error events on the same edge win.
- R10: A write to the transmit buffer (offset 0xC) while status bit 1 is clear latches `dat_i[7:0]` onto `tx_data_o`, pulses `tx_start_o` in the ack cycle and sets bit 1. While bit 1 is set, such a write changes nothing.
- R11: A `tx_done_i` pulse clears status bit 1.
- R12: Writes to offsets 0x0 and 0x8 and to any undecoded offset change no register. Reads of offset 0xC or of undecoded offsets return zero. Every request is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 4 | Byte offset of the register |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | One-cycle acknowledge |
| clk_div_o | output | 16 | Clock divider to both engines |
| char8_o | output | 1 | 1 = eight data bits, 0 = seven |
| parity_mode_o | output | 2 | 00 none, 01 even, 10 odd |
| stop2_o | output | 1 | 1 = two stop bits |
| cancel_o | output | 1 | One-cycle abort to both engines |
| tx_data_o | output | 8 | Character handed to the transmitter |
| tx_start_o | output | 1 | One-cycle start strobe to the transmitter |
| tx_done_i | input | 1 | Transmitter finished its frame |
| rx_valid_i | input | 1 | Receiver delivers a character |
| rx_data_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity mismatch on that character |
| rx_ferr_i | input | 1 | Stop bit was low on that character |

## Verification
Every bus result is due one cycle after the edge that accepts the request: `ack_o`, the read data, `cancel_o`, `tx_start_o`, the new configuration outputs and every clearing side effect. Receiver and transmitter strobes change the flags one edge after the strobe. The bench drives all inputs on falling edges and samples on falling edges. Each bus check therefore lands in the ack cycle, and a following falling-edge sample confirms that each pulse has ended. The receive path is swept over all 256 character values, with parity and framing errors mixed in arithmetically. Each character is checked through status, buffer and the cleared status.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
    localparam int WB_DW   = 32;
    localparam int DIV_W   = 16;
    localparam int DIV_LSB = WB_DW - DIV_W;
    localparam int NREG    = 4;
    localparam int CFG_W   = 4;
    localparam int PAD_W   = DIV_LSB - CFG_W;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CTRL   = 2'd1,
        REG_RXBUF  = 2'd2,
        REG_TXBUF  = 2'd3
    } reg_idx_e;

    localparam int ST_RXFULL = 0;
    localparam int ST_TXBUSY = 1;
    localparam int ST_OVR    = 2;
    localparam int ST_FERR   = 3;
    localparam int ST_PERR   = 4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             two_stop;
        logic [1:0]       parity;
        logic             char8;
    } ctrl_t;
endpackage

// File: rtl/uart_bus_port.sv
module uart_bus_port
    import uart_regs_pkg::*;
#(
    parameter int ADR_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            cyc_i,
    input  logic            stb_i,
    input  logic            we_i,
    input  logic [ADR_W-1:0] adr_i,
    output logic            ack_o,
    output logic [NREG-1:0] rd_stb_o,
    output logic [NREG-1:0] wr_stb_o
);
    typedef struct packed {
        logic ack;
    } port_t;

    port_t q, d;
    logic  take;

    assign take = cyc_i & stb_i & ~q.ack;

    always_comb begin
        d     = q;
        d.ack = take;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign ack_o = q.ack;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        logic hit;
        assign hit         = (adr_i == ADR_W'(g * 4));
        assign rd_stb_o[g] = take & ~we_i & hit;
        assign wr_stb_o[g] = take &  we_i & hit;
    end

    AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |=> !ack_o);                                   // R2
    AST_ACK_HAS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |-> $past(cyc_i && stb_i));                    // R2
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
    parameter int CHAR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rx_valid_i,
    input  logic [CHAR_W-1:0] rx_data_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i,
    input  logic              rd_buf_i,
    input  logic              rd_status_i,
    output logic [CHAR_W-1:0] rxd_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              perr_o,
    output logic              ferr_o
);
    typedef struct packed {
        logic [CHAR_W-1:0] rxd;
        logic              full;
        logic              ovr;
        logic              perr;
        logic              ferr;
    } rxs_t;

    rxs_t q, d;

    always_comb begin
        d = q;
        if (rd_buf_i) begin
            d.rxd  = '0;
            d.full = 1'b0;
        end
        if (rd_status_i) begin
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
        end
        if (rx_valid_i) begin
            d.rxd  = rx_data_i;
            d.full = 1'b1;
            if (q.full && !rd_buf_i) d.ovr  = 1'b1;
            if (rx_perr_i)           d.perr = 1'b1;
            if (rx_ferr_i)           d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign rxd_o  = q.rxd;
    assign full_o = q.full;
    assign ovr_o  = q.ovr;
    assign perr_o = q.perr;
    assign ferr_o = q.ferr;

    AST_RX_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_valid_i |=> (full_o && rxd_o == $past(rx_data_i)));          // R5
    AST_RX_READ_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_buf_i && !rx_valid_i) |=> !full_o);                         // R6
    AST_RX_PARITY_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_valid_i && rx_perr_i) |=> perr_o);                          // R7
    AST_RX_OVERRUN: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_valid_i && full_o && !rd_buf_i) |=> ovr_o);                 // R8
    AST_STATUS_READ_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_status_i && !rx_valid_i) |=> (!ovr_o && !perr_o && !ferr_o)); // R9
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int CHAR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [CHAR_W-1:0] wdata_i,
    input  logic              cancel_i,
    input  logic              tx_done_i,
    output logic [CHAR_W-1:0] tx_data_o,
    output logic              tx_start_o,
    output logic              busy_o
);
    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              busy;
        logic              start;
    } txs_t;

    txs_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (tx_done_i) d.busy = 1'b0;
        if (cancel_i) begin
            d.busy = 1'b0;
        end else if (wr_i && !q.busy) begin
            d.data  = wdata_i;
            d.busy  = 1'b1;
            d.start = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign tx_data_o  = q.data;
    assign tx_start_o = q.start;
    assign busy_o     = q.busy;

    AST_TX_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_start_o |-> ($past(!busy_o) && busy_o));          // R10
    AST_TX_START_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_start_o |=> !tx_start_o);                         // R10
    AST_TX_CANCEL_IDLES: assert property (@(posedge clk_i) disable iff (rst_i)
        cancel_i |=> !busy_o);                               // R4
    AST_TX_DONE_IDLES: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_done_i && !wr_i) |=> !busy_o);                   // R11
endmodule

// File: rtl/uart_wb_regs.sv
module uart_wb_regs
    import uart_regs_pkg::*;
#(
    parameter int ADR_W  = 4,
    parameter int CHAR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADR_W-1:0]  adr_i,
    input  logic [WB_DW-1:0]  dat_i,
    output logic [WB_DW-1:0]  dat_o,
    output logic              ack_o,
    output logic [DIV_W-1:0]  clk_div_o,
    output logic              char8_o,
    output logic [1:0]        parity_mode_o,
    output logic              stop2_o,
    output logic              cancel_o,
    output logic [CHAR_W-1:0] tx_data_o,
    output logic              tx_start_o,
    input  logic              tx_done_i,
    input  logic              rx_valid_i,
    input  logic [CHAR_W-1:0] rx_data_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic             cancel;
        logic [WB_DW-1:0] rdata;
    } top_t;

    top_t q, d;

    logic [NREG-1:0]   rd_stb, wr_stb;
    logic [CHAR_W-1:0] rxd;
    logic              rx_full, rx_ovr, rx_perr, rx_ferr, tx_busy;
    logic [WB_DW-1:0]  stat_w;
    logic              unused_dat;

    assign unused_dat = ^dat_i;

    uart_bus_port #(.ADR_W(ADR_W)) u_port (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cyc_i    (cyc_i),
        .stb_i    (stb_i),
        .we_i     (we_i),
        .adr_i    (adr_i),
        .ack_o    (ack_o),
        .rd_stb_o (rd_stb),
        .wr_stb_o (wr_stb)
    );

    uart_rx_flags #(.CHAR_W(CHAR_W)) u_rx (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rx_valid_i  (rx_valid_i),
        .rx_data_i   (rx_data_i),
        .rx_perr_i   (rx_perr_i),
        .rx_ferr_i   (rx_ferr_i),
        .rd_buf_i    (rd_stb[REG_RXBUF]),
        .rd_status_i (rd_stb[REG_STATUS]),
        .rxd_o       (rxd),
        .full_o      (rx_full),
        .ovr_o       (rx_ovr),
        .perr_o      (rx_perr),
        .ferr_o      (rx_ferr)
    );

    uart_tx_hold #(.CHAR_W(CHAR_W)) u_tx (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_i       (wr_stb[REG_TXBUF]),
        .wdata_i    (dat_i[CHAR_W-1:0]),
        .cancel_i   (wr_stb[REG_CTRL]),
        .tx_done_i  (tx_done_i),
        .tx_data_o  (tx_data_o),
        .tx_start_o (tx_start_o),
        .busy_o     (tx_busy)
    );

    always_comb begin
        stat_w            = '0;
        stat_w[ST_RXFULL] = rx_full;
        stat_w[ST_TXBUSY] = tx_busy;
        stat_w[ST_OVR]    = rx_ovr;
        stat_w[ST_FERR]   = rx_ferr;
        stat_w[ST_PERR]   = rx_perr;
    end

    always_comb begin
        d        = q;
        d.cancel = wr_stb[REG_CTRL];
        d.rdata  = '0;
        if (wr_stb[REG_CTRL])
            d.ctrl = {dat_i[WB_DW-1:DIV_LSB], dat_i[CFG_W-1:0]};
        unique case (1'b1)
            rd_stb[REG_STATUS]: d.rdata = stat_w;
            rd_stb[REG_CTRL]:   d.rdata = {q.ctrl.div, {PAD_W{1'b0}},
                                           q.ctrl.two_stop, q.ctrl.parity, q.ctrl.char8};
            rd_stb[REG_RXBUF]:  d.rdata = WB_DW'(rxd);
            default:            d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign dat_o         = q.rdata;
    assign cancel_o      = q.cancel;
    assign clk_div_o     = q.ctrl.div;
    assign char8_o       = q.ctrl.char8;
    assign parity_mode_o = q.ctrl.parity;
    assign stop2_o       = q.ctrl.two_stop;

    AST_CANCEL_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        cancel_o |=> !cancel_o);                                        // R4
    AST_CANCEL_WITH_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
        cancel_o |-> ack_o);                                            // R4
    AST_CTRL_DIV_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_i && stb_i && !ack_o && we_i && adr_i == ADR_W'(4))
        |=> clk_div_o == $past(dat_i[WB_DW-1:DIV_LSB]));                // R3
    AST_WRONLY_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_i && stb_i && !ack_o && !we_i && adr_i == ADR_W'(12))
        |=> dat_o == '0);                                               // R12
endmodule

// File: tb/tb_uart_wb_regs.sv
module tb_uart_wb_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [3:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic [31:0] rdat;
    logic        ack;
    logic [15:0] div;
    logic        c8, st2, cancel, tx_start;
    logic [1:0]  par;
    logic [7:0]  tx_data;
    logic        tx_done = 1'b0, rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
    logic [7:0]  rx_data = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] got;
    logic        cap_cancel, cap_start, cap_ack_before;

    always #10 clk = ~clk;

    uart_wb_regs dut (
        .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
        .clk_div_o(div), .char8_o(c8), .parity_mode_o(par), .stop2_o(st2),
        .cancel_o(cancel), .tx_data_o(tx_data), .tx_start_o(tx_start),
        .tx_done_i(tx_done), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One classic cycle; results sampled on the falling edge of the ack cycle.
    task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        cap_ack_before = ack;
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = v;
        @(negedge clk);
        check("R2 ack in cycle after request", {31'b0, ack}, 32'd1);
        check("R2 ack low before request", {31'b0, cap_ack_before}, 32'd0);
        got = rdat; cap_cancel = cancel; cap_start = tx_start;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
        check("R2 ack lasts one cycle", {31'b0, ack}, 32'd0);
    endtask

    task automatic rd(input logic [3:0] a); bus(1'b0, a, 32'h0); endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] v); bus(1'b1, a, v); endtask

    task automatic push(input logic [7:0] v, input logic pe, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = v; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_view(input logic [31:0] v);
        return {v[31:16], 12'h000, v[3:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cancel low", {31'b0, cancel}, 32'd0);
        check("R1 tx_start low", {31'b0, tx_start}, 32'd0);
        rd(4'h0); check("R1 status zero", got, 32'h0);
        rd(4'h4); check("R1 control zero", got, 32'h0);
        rd(4'h8); check("R1 rx buffer zero", got, 32'h0);

        // R3 / R4 control patterns
        foreach (ctrl_pats[i]) begin
            wr(4'h4, ctrl_pats[i]);
            check("R4 cancel in ack cycle", {31'b0, cap_cancel}, 32'd1);
            check("R4 cancel ended", {31'b0, cancel}, 32'd0);
            check("R3 divider out", {16'b0, div}, {16'b0, ctrl_pats[i][31:16]});
            check("R3 width/parity/stop out", {28'b0, st2, par, c8}, {28'b0, ctrl_pats[i][3:0]});
            rd(4'h4);
            check("R3 control readback", got, ctrl_view(ctrl_pats[i]));
            check("R3 control read no cancel", {31'b0, cap_cancel}, 32'd0);
        end

        // R12 read-only / write-only / undecoded offsets
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h6, 32'hFFFF_FFFF);
        rd(4'h0); check("R12 status write ignored", got, 32'h0);
        rd(4'h8); check("R12 rx write ignored", got, 32'h0);
        rd(4'h4); check("R12 undecoded write ignored", got, ctrl_view(ctrl_pats[2]));
        rd(4'hC); check("R12 tx buffer reads zero", got, 32'h0);
        rd(4'h5); check("R12 undecoded reads zero", got, 32'h0);

        // R10 / R11 / R4 transmit hand-off
        wr(4'hC, 32'hABCD_12A5);
        check("R10 start pulse", {31'b0, cap_start}, 32'd1);
        check("R10 start ended", {31'b0, tx_start}, 32'd0);
        check("R10 data latched", {24'b0, tx_data}, 32'hA5);
        rd(4'h0); check("R10 busy set", got, 32'h2);
        wr(4'hC, 32'h0000_003C);
        check("R10 busy write no start", {31'b0, cap_start}, 32'd0);
        check("R10 busy write ignored", {24'b0, tx_data}, 32'hA5);
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        rd(4'h0); check("R11 done clears busy", got, 32'h0);
        wr(4'hC, 32'h77);
        check("R10 data after idle", {24'b0, tx_data}, 32'h77);
        wr(4'h4, 32'h0002_0001);
        rd(4'h0); check("R4 control write clears busy", got, 32'h0);

        // R5 R6 R7 R9: sweep every character with mixed errors
        for (int v = 0; v < 256; v++) begin
            logic [7:0] c;
            logic pe, fe;
            c  = 8'(v);
            pe = c[0] ^ c[7];
            fe = c[4];
            push(c, pe, fe);
            rd(4'h0);
            check("R5 R7 status after frame", got, {27'b0, pe, fe, 3'b001});
            rd(4'h0);
            check("R9 errors cleared, full kept", got, 32'h1);
            rd(4'h8);
            check("R5 R6 rx data", got, {24'b0, c});
            rd(4'h0);
            check("R6 full cleared by buffer read", got, 32'h0);
        end

        // R8 overrun
        push(8'h11, 1'b0, 1'b0);
        push(8'h22, 1'b0, 1'b0);
        rd(4'h0); check("R8 overrun flagged", got, 32'h5);
        rd(4'h0); check("R9 overrun cleared", got, 32'h1);
        wr(4'h8, 32'h0);
        rd(4'h8); check("R8 newest kept", got, 32'h22);
        rd(4'h8); check("R6 buffer emptied", got, 32'h0);
        push(8'h33, 1'b0, 1'b0);
        rd(4'h0); check("R8 no overrun when empty", got, 32'h1);
        rd(4'h8); check("R5 single frame", got, 32'h33);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [31:0] ctrl_pats [3] = '{32'hFFFF_FFFF, 32'h1234_5678, 32'h0001_0005};
endmodule